// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block derives every control strobe needed to take one display sample from a single free-running system clock. It is meant to sit between a 12-bit serial-output converter and a shift-register column display. Each frame begins with a short active-high pulse that starts a conversion. After a short gap it sends a burst of exactly sixteen serial clock pulses, which clock out the leading zeros and the result bits. Each of those pulses is followed by a one-cycle sample enable, so the downstream shift logic captures the data line after it has settled. After a second gap it drives an active-low transfer strobe. That strobe moves the shifted word into the parallel display register and also clears the downstream sticky-one latch. The sequencer then idles until the frame period ends.

All timing is counted in system-clock cycles and set by parameters: frame length, start-pulse width, transfer-pulse width, serial half-period, sample delay and the gap between phases. With the defaults and a 1 MHz system clock, the frame is 400 cycles long, which gives about 2.5 kHz. The parameters must satisfy these constraints:

- 1 <= SHIFT_DLY < SCLK_HALF.
- GAP_CYC >= 1.
- FRAME_CYC >= START_W + 2*GAP_CYC + 32*SCLK_HALF + XFER_W.

An active-low reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `adc_frame_seq`

## Requirements
- R1: While rst_ni is low, conv_start_o=0, sclk_o=0, shift_en_o=0 and xfer_n_o=1. A frame then begins on the third rising clock edge after rst_ni goes high.
- R2: conv_start_o is high for exactly START_W cycles, at frame positions 0 to START_W-1.
- R3: Each frame holds exactly 16 sclk_o pulses, each high for SCLK_HALF cycles and then low for SCLK_HALF cycles. The first pulse rises at frame position START_W+GAP_CYC.
- R4: shift_en_o is a one-cycle pulse SHIFT_DLY cycles after each sclk_o rising edge, and it always falls while sclk_o is high.
- R5: xfer_n_o is low for exactly XFER_W cycles. Its fall comes GAP_CYC cycles after the low half of the 16th serial pulse ends.
- R6: The frame repeats every FRAME_CYC cycles without a break.
- R7: sclk_o is low outside the burst. sclk_o is never high while conv_start_o is high or xfer_n_o is low.
- R8: A reset asserted in any phase aborts the frame, and the next frame starts from position 0 as stated in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running system clock |
| rst_ni | input | 1 | active-low reset, asynchronous assert |
| conv_start_o | output | 1 | conversion-start pulse, active high |
| sclk_o | output | 1 | serial clock to the converter |
| shift_en_o | output | 1 | delayed sample enable for the shift logic |
| xfer_n_o | output | 1 | active-low transfer and clear strobe |

## Verification
Long uninterrupted runs over several frames show that the frame period and the per-frame count of serial pulses stay exact. Directed resets in the middle of the burst and during the transfer strobe show that an aborted frame restarts cleanly from position 0, rather than resuming where it stopped. Randomly placed resets of random length, separated by run lengths of random size, land in every phase and every serial half-period. These runs separate faults in the synchroniser latency, the phase boundaries and the half-period counter. Every output is compared in every cycle against a frame-position model.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LEAD,
    PH_BURST,
    PH_TRAIL,
    PH_XFER
  } phase_e;

  localparam int unsigned SCLK_PULSES = 16;
endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic q1, q2;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_no = q2;
endmodule

// File: rtl/fseq_frame_timer.sv
module fseq_frame_timer #(
  parameter int unsigned FRAME_CYC = 400,
  parameter int unsigned CW        = $clog2(FRAME_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] pos_d_o
);
  logic [CW-1:0] pos_q, pos_n;
  logic          run_q, run_n;
  logic          upd;

  // next-state
  always_comb begin
    run_n = 1'b1;
    if (!run_q) begin
      pos_n = '0;
    end else if (pos_q == CW'(FRAME_CYC - 1)) begin
      pos_n = '0;
    end else begin
      pos_n = pos_q + 1'b1;
    end
  end

  assign upd = 1'b1;

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      run_q <= 1'b0;
    end else if (upd) begin
      pos_q <= pos_n;
      run_q <= run_n;
    end
  end

  assign pos_d_o = pos_n;
endmodule

// File: rtl/fseq_phase_decode.sv
module fseq_phase_decode
  import fseq_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 400,
  parameter int unsigned CW        = $clog2(FRAME_CYC),
  parameter int unsigned START_W   = 2,
  parameter int unsigned XFER_W    = 2,
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned GAP_CYC   = 2
) (
  input  logic [CW-1:0] pos_i,
  output phase_e        phase_o
);
  localparam int unsigned BURST_BEG = START_W + GAP_CYC;
  localparam int unsigned BURST_END = BURST_BEG + 2 * SCLK_HALF * SCLK_PULSES;
  localparam int unsigned XFER_BEG  = BURST_END + GAP_CYC;
  localparam int unsigned XFER_END  = XFER_BEG + XFER_W;

  always_comb begin
    if (pos_i < CW'(START_W))        phase_o = PH_START;
    else if (pos_i < CW'(BURST_BEG)) phase_o = PH_LEAD;
    else if (pos_i < CW'(BURST_END)) phase_o = PH_BURST;
    else if (pos_i < CW'(XFER_BEG))  phase_o = PH_TRAIL;
    else if (pos_i < CW'(XFER_END))  phase_o = PH_XFER;
    else                             phase_o = PH_IDLE;
  end
endmodule

// File: rtl/fseq_burst_gen.sv
module fseq_burst_gen
  import fseq_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned SHIFT_DLY = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_d_i,
  output logic   sclk_d_o,
  output logic   shift_d_o
);
  localparam int unsigned HCW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [HCW-1:0] hc_q, hc_n;
  logic           lvl_q, lvl_n;
  logic           inb_q, inb_n;
  logic           upd;

  assign upd = (phase_d_i == PH_BURST) || inb_q;

  // next-state
  always_comb begin
    hc_n  = hc_q;
    lvl_n = lvl_q;
    inb_n = inb_q;
    if (phase_d_i != PH_BURST) begin
      hc_n  = '0;
      lvl_n = 1'b0;
      inb_n = 1'b0;
    end else if (!inb_q) begin
      hc_n  = '0;
      lvl_n = 1'b1;
      inb_n = 1'b1;
    end else if (hc_q == HCW'(SCLK_HALF - 1)) begin
      hc_n  = '0;
      lvl_n = ~lvl_q;
    end else begin
      hc_n  = hc_q + 1'b1;
    end
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      lvl_q <= 1'b0;
      inb_q <= 1'b0;
    end else if (upd) begin
      hc_q  <= hc_n;
      lvl_q <= lvl_n;
      inb_q <= inb_n;
    end
  end

  assign sclk_d_o  = lvl_n;
  assign shift_d_o = lvl_n && (hc_n == HCW'(SHIFT_DLY));
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import fseq_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 400,
  parameter int unsigned START_W   = 2,
  parameter int unsigned XFER_W    = 2,
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned SHIFT_DLY = 1,
  parameter int unsigned GAP_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic conv_start_o,
  output logic sclk_o,
  output logic shift_en_o,
  output logic xfer_n_o
);
  localparam int unsigned CW = $clog2(FRAME_CYC);

  logic          srst_n;
  logic [CW-1:0] pos_d;
  phase_e        phase_d;
  logic          sclk_d, shift_d;
  logic          start_q, sclk_q, shift_q, xfer_n_q;

  fseq_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  fseq_frame_timer #(.FRAME_CYC(FRAME_CYC), .CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (srst_n),
    .pos_d_o (pos_d)
  );

  fseq_phase_decode #(
    .FRAME_CYC(FRAME_CYC), .CW(CW), .START_W(START_W), .XFER_W(XFER_W),
    .SCLK_HALF(SCLK_HALF), .GAP_CYC(GAP_CYC)
  ) u_dec (
    .pos_i   (pos_d),
    .phase_o (phase_d)
  );

  fseq_burst_gen #(.SCLK_HALF(SCLK_HALF), .SHIFT_DLY(SHIFT_DLY)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .phase_d_i (phase_d),
    .sclk_d_o  (sclk_d),
    .shift_d_o (shift_d)
  );

  // output register stage, decoded from next state
  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      start_q  <= 1'b0;
      sclk_q   <= 1'b0;
      shift_q  <= 1'b0;
      xfer_n_q <= 1'b1;
    end else begin
      start_q  <= (phase_d == PH_START);
      sclk_q   <= sclk_d;
      shift_q  <= shift_d;
      xfer_n_q <= (phase_d != PH_XFER);
    end
  end

  assign conv_start_o = start_q;
  assign sclk_o       = sclk_q;
  assign shift_en_o   = shift_q;
  assign xfer_n_o     = xfer_n_q;
endmodule

// File: rtl/adc_frame_seq_checker.sv
module adc_frame_seq_checker #(
  parameter int unsigned FRAME_CYC = 400,
  parameter int unsigned START_W   = 2,
  parameter int unsigned XFER_W    = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_start_o,
  input logic sclk_o,
  input logic shift_en_o,
  input logic xfer_n_o
);
  logic [15:0] start_run, xfer_run, rise_cnt, per_cnt;
  logic        sclk_prev, start_prev, seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_run  <= '0;
      xfer_run   <= '0;
      rise_cnt   <= '0;
      per_cnt    <= '0;
      sclk_prev  <= 1'b0;
      start_prev <= 1'b0;
      seen       <= 1'b0;
    end else begin
      start_run  <= conv_start_o ? start_run + 1'b1 : '0;
      xfer_run   <= !xfer_n_o ? xfer_run + 1'b1 : '0;
      sclk_prev  <= sclk_o;
      start_prev <= conv_start_o;
      if (conv_start_o) rise_cnt <= '0;
      else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
      if (conv_start_o && !start_prev) begin
        per_cnt <= 16'd1;
        seen    <= 1'b1;
      end else begin
        per_cnt <= per_cnt + 1'b1;
      end
    end
  end

  assert_start_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_start_o) |-> (start_run == 16'(START_W)));

  assert_burst_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_n_o) |-> (rise_cnt == 16'd16));

  assert_shift_in_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> sclk_o);

  assert_shift_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |=> !shift_en_o);

  assert_xfer_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_n_o) |-> (xfer_run == 16'(XFER_W)));

  assert_frame_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(conv_start_o) && seen) |-> (per_cnt == 16'(FRAME_CYC)));

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_start_o, sclk_o, !xfer_n_o}));
endmodule

bind adc_frame_seq adc_frame_seq_checker #(
  .FRAME_CYC(FRAME_CYC), .START_W(START_W), .XFER_W(XFER_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_o (conv_start_o),
  .sclk_o       (sclk_o),
  .shift_en_o   (shift_en_o),
  .xfer_n_o     (xfer_n_o)
);

// File: tb/adc_frame_seq_tb_top.sv
`timescale 1ns/1ps
module adc_frame_seq_tb_top;
  localparam int FRAME = 400;
  localparam int SW    = 2;
  localparam int XW    = 2;
  localparam int H     = 4;
  localparam int SD    = 1;
  localparam int G     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start, sclk, shift_en, xfer_n;
  int   cnt = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  int   last_rise = -1;
  int   rises = 0;
  int   cyc = 0;
  logic prev_start = 1'b0;
  logic prev_sclk = 1'b0;

  always #2 clk = ~clk;

  adc_frame_seq #(
    .FRAME_CYC(FRAME), .START_W(SW), .XFER_W(XW),
    .SCLK_HALF(H), .SHIFT_DLY(SD), .GAP_CYC(G)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_o(conv_start),
    .sclk_o(sclk), .shift_en_o(shift_en), .xfer_n_o(xfer_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  // expected {start, sclk, shift, xfer_n} at frame position t
  function automatic logic [3:0] exp_out(int t);
    int b0, be, x0, off;
    logic s, c, e, x;
    b0 = SW + G;
    be = b0 + 2 * H * 16;
    x0 = be + G;
    s = (t < SW);
    c = 1'b0;
    e = 1'b0;
    if (t >= b0 && t < be) begin
      off = t - b0;
      c = ((off / H) % 2) == 0;
      e = (off % (2 * H)) == SD;
    end
    x = !(t >= x0 && t < x0 + XW);
    return {s, c, e, x};
  endfunction

  function automatic logic [3:0] expect_now();
    if (!rst_n || cnt < 3) return 4'b0001;
    return exp_out((cnt - 3) % FRAME);
  endfunction

  task automatic chk(string req, logic act, logic ex, string what);
    n_vec++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, ex, cyc);
    end
  endtask

  task automatic step();
    logic [3:0] e;
    @(negedge clk);
    cyc++;
    e = expect_now();
    chk((!rst_n || cnt < 3) ? "R1" : "R2", conv_start, e[3], "conv_start");
    chk((!rst_n || cnt < 3) ? "R1" : "R3", sclk,       e[2], "sclk");
    chk((!rst_n || cnt < 3) ? "R1" : "R4", shift_en,   e[1], "shift_en");
    chk((!rst_n || cnt < 3) ? "R1" : "R5", xfer_n,     e[0], "xfer_n");
    // R7: no serial clock during start or transfer
    chk("R7", sclk && (conv_start || !xfer_n), 1'b0, "sclk overlap");
    // R6 / R3: frame-level observations at the ports
    if (!rst_n) begin
      last_rise = -1;
      rises = 0;
    end else begin
      if (sclk && !prev_sclk) rises++;
      if (conv_start && !prev_start) begin
        if (last_rise >= 0) begin
          chk("R6", (cyc - last_rise) == FRAME, 1'b1, "frame period");
          chk("R3", rises == 16, 1'b1, "sclk pulses per frame");
        end
        last_rise = cyc;
        rises = 0;
      end
    end
    prev_start = conv_start;
    prev_sclk  = sclk;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    run(5);                       // R1 reset state
    rst_n = 1'b1;
    run(2);
    chk("R1", conv_start, 1'b0, "start before sync release");
    step();
    chk("R1", conv_start, 1'b1, "first frame on third edge");
    run(3 * FRAME);
    // R8: reset in the middle of the burst
    run(60);
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    run(3);
    chk("R8", conv_start && sclk == 1'b0, 1'b1, "restart after mid-burst reset");
    run(FRAME + 20);
    // R8: reset while transfer strobe is low
    while (xfer_n !== 1'b0) step();
    rst_n = 1'b0;
    step();
    chk("R8", xfer_n, 1'b1, "transfer released by reset");
    rst_n = 1'b1;
    run(FRAME + 10);
    // random resets
    for (int k = 0; k < 30; k++) begin
      run($urandom_range(5, 900));
      rst_n = 1'b0;
      run($urandom_range(1, 4));
      rst_n = 1'b1;
    end
    run(2 * FRAME + 5);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule